// File: doc/BRIEF.md
# Banked Extended RAM Access Port

This block gives a byte-wide register bus indirect access to a large extended RAM. The RAM sits behind a bank-select bit. With bank 1 selected, software sees three things: a two-byte RAM address pointer, a single data-port byte and an extended control register. Each data-port read or write reaches the RAM location named by the pointer. The RAM itself is outside the block and is reached over a synchronous single-port interface. The block drives enable, write enable, address and write data, and the RAM returns its read data one clock later.

An optional burst mode advances the pointer after every data-port access. Software sets a start address once and then streams bytes through the data port. The pointer wraps at the top of the configured RAM size. With bank 0 selected, the upper offsets map to a small general-purpose storage array instead, and the extended RAM and its pointer are not touched. A build parameter can remove burst support. The burst bit then stays as a plain storage bit.

Top module: `xram_port`

## Requirements
- R1: After a synchronous reset, the bank-select register (offset 0x0A) and the extended control register (bank 1, offset 0x4A) read 0x00. The RAM pointer reads 0x0000 and `bus_rvalid` is low.
- R2: The register at 0x0A can be read and written in both banks. Its bit 4 selects bank 1 when it is 1. Offsets 0x4A, 0x50, 0x51 and 0x53 decode as bank 1 registers only while that bit is 1.
- R3: In bank 1, offset 0x50 holds pointer bits 7:0 and offset 0x51 holds the pointer bits above bit 7. Pointer bits at or above log2(RAM_BYTES) do not exist and read back as 0.
- R4: A bank 1 write to offset 0x53 writes the data byte into the RAM at the current pointer (`ram_en`=1, `ram_we`=1) in the same clock cycle.
- R5: A read strobe is answered on `bus_rdata`, with `bus_rvalid` high, in the cycle after the strobe. A bank 1 read of 0x53 returns the RAM byte at the pointer value held before any increment.
- R6: When bit 5 of offset 0x4A is 1 and burst support is built in, every bank 1 read or write of 0x53 adds one to the pointer.
- R7: A burst increment from address RAM_BYTES-1 wraps the pointer to 0.
- R8: With BURST_SUPPORT=0, bit 5 of 0x4A still stores and reads back, but data-port accesses never move the pointer.
- R9: In bank 0, offsets 0x40 to 0x7F (including 0x50 to 0x53) read and write a general-purpose storage array. They never assert `ram_en` and never change the pointer.
- R10: With burst off, the pointer keeps its value across data-port accesses. It changes only on writes to 0x50 or 0x51.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | log2(RAM_BYTES) | RAM address (current pointer) |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_en |

## Verification
The assertions assume that read and write strobes never occur in the same cycle. They also assume that each strobe lasts a single cycle, with the register offset and write data steady while it is high. They further assume that the external RAM answers a read on the clock after `ram_en`. The stimulus issues every access through a task that raises exactly one strobe for one cycle and drops it before the next access. Both RAM models in the bench register their read data on the enable edge.

// File: rtl/xram_pkg.sv
package xram_pkg;

  localparam logic [7:0] OFS_BANKCTL  = 8'h0A;
  localparam logic [7:0] OFS_XCTL     = 8'h4A;
  localparam logic [7:0] OFS_PTR_LO   = 8'h50;
  localparam logic [7:0] OFS_PTR_HI   = 8'h51;
  localparam logic [7:0] OFS_DATAPORT = 8'h53;
  localparam logic [7:0] OFS_SCR_BASE = 8'h40;

  localparam int BANK_BIT  = 4;
  localparam int BURST_BIT = 5;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_SCR  = 2'd3
  } rsrc_e;

  typedef struct packed {
    logic bankctl;
    logic xctl;
    logic ptr_lo;
    logic ptr_hi;
    logic dport;
    logic scr;
  } hit_t;

endpackage

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
#(
  parameter int BUS_AW        = 7,
  parameter int SCRATCH_DEPTH = 64
) (
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bank_sel,
  output hit_t              hit
);

  localparam int SCR_LO = int'(OFS_SCR_BASE);
  localparam int SCR_HI = SCR_LO + SCRATCH_DEPTH;

  logic [7:0] a8;
  logic       in_scr;

  assign a8     = 8'(bus_addr);
  assign in_scr = (int'(a8) >= SCR_LO) && (int'(a8) < SCR_HI);

  always_comb begin
    hit         = '0;
    hit.bankctl = (a8 == OFS_BANKCTL);
    if (bank_sel) begin
      hit.xctl   = (a8 == OFS_XCTL);
      hit.ptr_lo = (a8 == OFS_PTR_LO);
      hit.ptr_hi = (a8 == OFS_PTR_HI);
      hit.dport  = (a8 == OFS_DATAPORT);
    end else begin
      hit.scr    = in_scr;
    end
  end

endmodule

// File: rtl/xram_ctrl_regs.sv
module xram_ctrl_regs
  import xram_pkg::*;
#(
  parameter bit BURST_SUPPORT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_bankctl,
  input  logic       wr_xctl,
  input  logic [7:0] wdata,
  output logic [7:0] bankctl_q,
  output logic [7:0] xctl_q,
  output logic       bank_sel,
  output logic       burst_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bankctl_q <= '0;
      xctl_q    <= '0;
    end else begin
      if (wr_bankctl) bankctl_q <= wdata;
      if (wr_xctl)    xctl_q    <= wdata;
    end
  end

  assign bank_sel = bankctl_q[BANK_BIT];

  generate
    if (BURST_SUPPORT) begin : g_burst
      assign burst_en = xctl_q[BURST_BIT];
    end else begin : g_no_burst
      assign burst_en = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/xram_addr_ptr.sv
module xram_addr_ptr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          step,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] ptr,
  output logic [7:0]    lo_byte,
  output logic [7:0]    hi_byte
);

  logic [15:0] ptr_ext;

  assign ptr_ext = 16'(ptr);
  assign lo_byte = ptr_ext[7:0];
  assign hi_byte = ptr_ext[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (wr_lo) begin
      ptr <= AW'({ptr_ext[15:8], wdata});
    end else if (wr_hi) begin
      ptr <= AW'({wdata, ptr_ext[7:0]});
    end else if (step) begin
      ptr <= ptr + AW'(1);
    end
  end

endmodule

// File: rtl/xram_scratch.sv
module xram_scratch #(
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end

endmodule

// File: rtl/xram_port.sv
module xram_port
  import xram_pkg::*;
#(
  parameter int RAM_BYTES     = 2048,
  parameter bit BURST_SUPPORT = 1'b1,
  parameter int BUS_AW        = 7,
  parameter int SCRATCH_DEPTH = 64,
  localparam int AW           = $clog2(RAM_BYTES),
  localparam int SIW          = $clog2(SCRATCH_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);

  hit_t       hit;
  logic       bank_sel, burst_en;
  logic [7:0] bankctl_q, xctl_q;
  logic [7:0] ptr_lo_b, ptr_hi_b;
  logic [7:0] scr_rdata;
  logic       dport_acc;
  logic [7:0] reg_val;
  rsrc_e      src_now, rsrc_q;
  logic [7:0] reg_q;
  logic       rvalid_q;

  xram_decode #(
    .BUS_AW       (BUS_AW),
    .SCRATCH_DEPTH(SCRATCH_DEPTH)
  ) u_dec (
    .bus_addr(bus_addr),
    .bank_sel(bank_sel),
    .hit     (hit)
  );

  xram_ctrl_regs #(
    .BURST_SUPPORT(BURST_SUPPORT)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_bankctl(bus_wr & hit.bankctl),
    .wr_xctl   (bus_wr & hit.xctl),
    .wdata     (bus_wdata),
    .bankctl_q (bankctl_q),
    .xctl_q    (xctl_q),
    .bank_sel  (bank_sel),
    .burst_en  (burst_en)
  );

  assign dport_acc = (bus_wr | bus_rd) & hit.dport;

  xram_addr_ptr #(
    .AW(AW)
  ) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .wr_lo  (bus_wr & hit.ptr_lo),
    .wr_hi  (bus_wr & hit.ptr_hi),
    .step   (dport_acc & burst_en),
    .wdata  (bus_wdata),
    .ptr    (ram_addr),
    .lo_byte(ptr_lo_b),
    .hi_byte(ptr_hi_b)
  );

  xram_scratch #(
    .DEPTH(SCRATCH_DEPTH)
  ) u_scr (
    .clk  (clk),
    .we   (bus_wr & hit.scr),
    .re   (bus_rd & hit.scr),
    .idx  (bus_addr[SIW-1:0]),
    .wdata(bus_wdata),
    .rdata(scr_rdata)
  );

  // RAM port driven in the access cycle from the current pointer
  assign ram_en    = dport_acc;
  assign ram_we    = bus_wr & hit.dport;
  assign ram_wdata = bus_wdata;

  // Read source selection and register read value
  always_comb begin
    reg_val = '0;
    src_now = SRC_NONE;
    if (hit.dport) begin
      src_now = SRC_RAM;
    end else if (hit.scr) begin
      src_now = SRC_SCR;
    end else begin
      src_now = SRC_REG;
      unique case (1'b1)
        hit.bankctl: reg_val = bankctl_q;
        hit.xctl:    reg_val = xctl_q;
        hit.ptr_lo:  reg_val = ptr_lo_b;
        hit.ptr_hi:  reg_val = ptr_hi_b;
        default:     reg_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsrc_q   <= SRC_NONE;
      reg_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) begin
        rsrc_q <= src_now;
        reg_q  <= reg_val;
      end
    end
  end

  always_comb begin
    unique case (rsrc_q)
      SRC_RAM: bus_rdata = ram_rdata;
      SRC_SCR: bus_rdata = scr_rdata;
      SRC_REG: bus_rdata = reg_q;
      default: bus_rdata = '0;
    endcase
  end

  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/xram_port_chk.sv
module xram_port_chk #(
  parameter int RAM_BYTES     = 2048,
  parameter bit BURST_SUPPORT = 1'b1,
  parameter int BUS_AW        = 7,
  localparam int AW           = $clog2(RAM_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic              bus_rvalid,
  input logic              ram_en,
  input logic              ram_we,
  input logic [AW-1:0]     ram_addr,
  input logic [7:0]        ram_wdata
);

  logic [7:0] a8;
  logic       bank_m, burst_m;
  logic       ptr_wr;

  assign a8     = 8'(bus_addr);
  assign ptr_wr = bank_m && bus_wr && (a8 == 8'h50 || a8 == 8'h51);

  // Independent view of bank and burst state, taken from bus traffic
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_m  <= 1'b0;
      burst_m <= 1'b0;
    end else begin
      if (bus_wr && a8 == 8'h0A) bank_m <= bus_wdata[4];
      if (bus_wr && bank_m && a8 == 8'h4A) burst_m <= bus_wdata[5] & BURST_SUPPORT;
    end
  end

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  a_r4_dport_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bank_m && a8 == 8'h53) |-> (ram_en && ram_we && ram_wdata == bus_wdata));

  a_r9_bank0_no_ram: assert property (@(posedge clk) disable iff (rst)
    (!bank_m) |-> !ram_en);

  a_r5_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  a_r5_rvalid_only: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  a_r6_burst_step: assert property (@(posedge clk) disable iff (rst)
    (ram_en && burst_m && !ptr_wr) |=> ram_addr == AW'($past(ram_addr) + AW'(1)));

  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!ptr_wr && !(ram_en && burst_m)) |=> $stable(ram_addr));

endmodule

bind xram_port xram_port_chk #(
  .RAM_BYTES    (RAM_BYTES),
  .BURST_SUPPORT(BURST_SUPPORT),
  .BUS_AW       (BUS_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rvalid(bus_rvalid),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata)
);

// File: tb/xram_port_bench.sv
`timescale 1ns/1ps
module xram_port_bench;

  localparam int RAM_BYTES = 2048;
  localparam int AW        = $clog2(RAM_BYTES);
  localparam int NVEC      = 41;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rdata_a, rdata_b;
  logic       rvalid_a, rvalid_b;
  logic       en_a, we_a, en_b, we_b;
  logic [AW-1:0] addr_a, addr_b;
  logic [7:0] wd_a, wd_b, rd_a, rd_b;
  logic [7:0] mem_a [RAM_BYTES];
  logic [7:0] mem_b [RAM_BYTES];

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  xram_port #(.RAM_BYTES(RAM_BYTES), .BURST_SUPPORT(1'b1)) u_xram_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .bus_rvalid(rvalid_a),
    .ram_en(en_a), .ram_we(we_a), .ram_addr(addr_a), .ram_wdata(wd_a), .ram_rdata(rd_a));

  xram_port #(.RAM_BYTES(RAM_BYTES), .BURST_SUPPORT(1'b0)) u_xram_port_nb (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_rvalid(rvalid_b),
    .ram_en(en_b), .ram_we(we_b), .ram_addr(addr_b), .ram_wdata(wd_b), .ram_rdata(rd_b));

  // Synchronous RAM models
  initial begin
    for (int i = 0; i < RAM_BYTES; i++) begin
      mem_a[i] = 8'h00;
      mem_b[i] = 8'h00;
    end
  end
  always @(posedge clk) begin
    if (en_a) begin
      if (we_a) mem_a[addr_a] <= wd_a;
      rd_a <= mem_a[addr_a];
    end
    if (en_b) begin
      if (we_b) mem_b[addr_b] <= wd_b;
      rd_b <= mem_b[addr_b];
    end
  end

  // {req, op(1=write,2=read), offset, wdata, expected}
  localparam logic [29:0] VEC [NVEC] = '{
    {4'd2,  2'd1, 8'h0A, 8'h10, 8'h00},  // R2 select bank 1
    {4'd2,  2'd2, 8'h0A, 8'h00, 8'h10},  // R2
    {4'd3,  2'd1, 8'h50, 8'h34, 8'h00},  // R3
    {4'd3,  2'd1, 8'h51, 8'hFF, 8'h00},  // R3
    {4'd3,  2'd2, 8'h51, 8'h00, 8'h07},  // R3 upper bits read 0
    {4'd3,  2'd2, 8'h50, 8'h00, 8'h34},  // R3
    {4'd4,  2'd1, 8'h53, 8'hA5, 8'h00},  // R4
    {4'd5,  2'd2, 8'h53, 8'h00, 8'hA5},  // R5
    {4'd10, 2'd2, 8'h50, 8'h00, 8'h34},  // R10 no step
    {4'd6,  2'd1, 8'h4A, 8'h20, 8'h00},  // R6 burst on
    {4'd6,  2'd2, 8'h4A, 8'h00, 8'h20},  // R6
    {4'd6,  2'd1, 8'h53, 8'h11, 8'h00},  // R6
    {4'd6,  2'd1, 8'h53, 8'h22, 8'h00},  // R6
    {4'd6,  2'd2, 8'h50, 8'h00, 8'h36},  // R6 two steps
    {4'd3,  2'd1, 8'h50, 8'h34, 8'h00},  // R3
    {4'd5,  2'd2, 8'h53, 8'h00, 8'h11},  // R5 pre-increment value
    {4'd5,  2'd2, 8'h53, 8'h00, 8'h22},  // R5
    {4'd6,  2'd2, 8'h50, 8'h00, 8'h36},  // R6 reads step too
    {4'd3,  2'd1, 8'h51, 8'h07, 8'h00},  // R3
    {4'd3,  2'd1, 8'h50, 8'hFF, 8'h00},  // R3
    {4'd7,  2'd1, 8'h53, 8'h5A, 8'h00},  // R7 top byte
    {4'd7,  2'd2, 8'h50, 8'h00, 8'h00},  // R7 wrapped low
    {4'd7,  2'd2, 8'h51, 8'h00, 8'h00},  // R7 wrapped high
    {4'd3,  2'd1, 8'h50, 8'hFF, 8'h00},  // R3
    {4'd3,  2'd1, 8'h51, 8'h07, 8'h00},  // R3
    {4'd7,  2'd2, 8'h53, 8'h00, 8'h5A},  // R7 read at top
    {4'd7,  2'd2, 8'h50, 8'h00, 8'h00},  // R7
    {4'd9,  2'd1, 8'h0A, 8'h00, 8'h00},  // R9 bank 0
    {4'd9,  2'd1, 8'h50, 8'h99, 8'h00},  // R9
    {4'd9,  2'd1, 8'h53, 8'h77, 8'h00},  // R9
    {4'd9,  2'd2, 8'h50, 8'h00, 8'h99},  // R9 scratch
    {4'd9,  2'd2, 8'h53, 8'h00, 8'h77},  // R9 scratch
    {4'd2,  2'd1, 8'h0A, 8'h10, 8'h00},  // R2 back to bank 1
    {4'd9,  2'd2, 8'h50, 8'h00, 8'h00},  // R9 pointer untouched
    {4'd9,  2'd2, 8'h53, 8'h00, 8'h00},  // R9 RAM untouched
    {4'd10, 2'd1, 8'h4A, 8'h00, 8'h00},  // R10 burst off
    {4'd3,  2'd1, 8'h50, 8'hFF, 8'h00},  // R3
    {4'd3,  2'd1, 8'h51, 8'h07, 8'h00},  // R3
    {4'd10, 2'd2, 8'h53, 8'h00, 8'h5A},  // R10
    {4'd10, 2'd2, 8'h53, 8'h00, 8'h5A},  // R10 same byte again
    {4'd10, 2'd2, 8'h50, 8'h00, 8'hFF}   // R10 pointer held
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a[6:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] va, output logic [7:0] vb,
                    output logic ok);
    @(negedge clk);
    bus_addr = a[6:0]; bus_rd = 1'b1;
    @(negedge clk);
    va = rdata_a; vb = rdata_b; ok = rvalid_a;
    bus_rd = 1'b0;
  endtask

  task automatic reset_checks;
    logic [7:0] va, vb;
    logic ok;
    chk(1, {7'd0, rvalid_a}, 8'h00);      // R1 rvalid low
    rd(8'h0A, va, vb, ok); chk(1, va, 8'h00);   // R1
    chk(5, {7'd0, ok}, 8'h01);            // R5 rvalid after strobe
    wr(8'h0A, 8'h10);
    rd(8'h4A, va, vb, ok); chk(1, va, 8'h00);   // R1
    rd(8'h50, va, vb, ok); chk(1, va, 8'h00);   // R1
    rd(8'h51, va, vb, ok); chk(1, va, 8'h00);   // R1
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] va, vb;
    logic ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    reset_checks();
    wr(8'h0A, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][25:24] == 2'd1) begin
        wr(VEC[i][23:16], VEC[i][15:8]);
      end else begin
        rd(VEC[i][23:16], va, vb, ok);
        chk(int'(VEC[i][29:26]), va, VEC[i][7:0]);
      end
    end

    // R2: offset 0x4A in bank 0 is scratch, not the control register
    wr(8'h0A, 8'h00);
    wr(8'h4A, 8'h55);
    rd(8'h4A, va, vb, ok); chk(2, va, 8'h55);
    wr(8'h0A, 8'h10);
    rd(8'h4A, va, vb, ok); chk(2, va, 8'h00);

    // R8: variant without burst support
    wr(8'h4A, 8'h20);
    rd(8'h4A, va, vb, ok); chk(8, vb, 8'h20);
    wr(8'h50, 8'h00);
    wr(8'h51, 8'h00);
    wr(8'h53, 8'hC3);
    wr(8'h53, 8'h3C);
    rd(8'h50, va, vb, ok); chk(8, vb, 8'h00);
    rd(8'h53, va, vb, ok); chk(8, vb, 8'h3C);
    rd(8'h50, va, vb, ok); chk(8, vb, 8'h00);
    rd(8'h50, va, vb, ok); chk(6, va, 8'h03);  // R6 burst instance stepped 3 times

    // R1: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reset_checks();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule